// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel behind an 8-bit register interface, of the kind used as a system tick or one-shot delay source. Software first writes a control byte that selects the channel and sets its access style, counting mode and number format. It then loads the count as two data bytes, low byte first. Once the high byte arrives, the count steps down by one on every cycle in which the external tick enable is high. The nominal tick rate is about 1.19 MHz.

The count can be read at any time as two bytes, low byte first. A count-latch command freezes a snapshot so that both bytes come from the same instant, even while the counter keeps running. In one-shot mode the output rises when the count runs out and stays high. In the two periodic modes the count reloads from the stored period. Settings that the channel cannot honour raise an error flag instead of being carried out.

Top module: `pit_channel`

## Requirements
- R1: After reset, out_q and cfg_err are low and the count reads back as 0x00 (low byte) then 0x00 (high byte).
- R2: A control byte (ctrl_sel=1) is split as select [7:6], access [5:4], mode [3:1] and BCD [0]. Only a byte whose select equals CHAN_SEL (default 0) affects the channel. A byte with select 1 or 2 changes neither the latch nor cfg_err.
- R3: A control byte with access 00 is a latch command. It copies the live count and points the read sequence at the low byte. It has no effect while an earlier latch has not yet been read out.
- R4: Data reads (ctrl_sel=0) return the low byte and the high byte in turn, combinationally in the cycle rd_en is high. Reading the high byte of a latched value releases the latch, so later reads show the live count.
- R5: A data write to the low byte replaces bits [7:0] of the count, halts any countdown and drives out_q low in the next cycle.
- R6: The following data write to the high byte completes the 16-bit value and stores it as the period. Counting starts only if that value is nonzero.
- R7: While the channel is counting, the count falls by exactly one for each cycle with tick_en high, and it does not change in cycles with tick_en low.
- R8: In mode 0, the tick that takes the count from 1 to 0 sets out_q high, and the count then holds at 0. out_q stays high until the next low-byte write.
- R9: In modes 2 and 3, the tick that arrives when the count is 1 reloads the stored period instead, and out_q stays low.
- R10: A programming byte for this channel sets cfg_err if its access is not 11, if BCD is 1, or if its mode is not 0, 2 or 3. A valid programming byte clears cfg_err. A select of 3 (read-back) sets cfg_err. A latch command leaves cfg_err unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| ctrl_sel | input | 1 | 1 = control byte, 0 = data byte |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data, valid in the rd_en cycle |
| out_q | output | 1 | Timer output |
| cfg_err | output | 1 | Unsupported setting flag |

## Verification
Read data is combinational from the current pointer and count, so the bench samples rdata in the same cycle it raises rd_en, shortly after the falling edge. Writes, latch commands and ticks take effect at the next rising edge, so out_q, cfg_err and the count are sampled on the falling edge that follows. A burst of n tick cycles therefore shows exactly n decrements. The bench keeps tick_en low during every read and write so that each expected count is fixed.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef struct packed {
      logic [1:0] sel;
      logic [1:0] acc;
      logic [2:0] mode;
      logic       bcd;
   } ctrl_word_t;

   localparam logic [1:0] ACC_LATCH   = 2'b00;
   localparam logic [1:0] ACC_LOHI    = 2'b11;
   localparam logic [1:0] SEL_READBK  = 2'b11;
   localparam logic [2:0] MODE_TERMCT = 3'd0;
   localparam logic [2:0] MODE_RATE   = 3'd2;
   localparam logic [2:0] MODE_SQUARE = 3'd3;
endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
   import pit_pkg::*;
#(
   parameter int CHAN_SEL = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic [7:0] ctrl_byte,
   output logic       latch_cmd,
   output logic       periodic,
   output logic       cfg_err
);
   ctrl_word_t word;
   logic       hit, program_cmd, bad_cfg, readback;
   logic [2:0] mode_q;

   assign word        = ctrl_word_t'(ctrl_byte);
   assign hit         = ctrl_wr && (word.sel == 2'(CHAN_SEL));
   assign latch_cmd   = hit && (word.acc == ACC_LATCH);
   assign program_cmd = hit && (word.acc != ACC_LATCH);
   assign readback    = ctrl_wr && (word.sel == SEL_READBK);
   assign bad_cfg     = (word.acc != ACC_LOHI) || word.bcd ||
                        !((word.mode == MODE_TERMCT) || (word.mode == MODE_RATE) ||
                          (word.mode == MODE_SQUARE));
   assign periodic    = (mode_q == MODE_RATE) || (mode_q == MODE_SQUARE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_TERMCT;
         cfg_err <= 1'b0;
      end else if (program_cmd) begin
         mode_q  <= word.mode;
         cfg_err <= bad_cfg;
      end else if (readback) begin
         cfg_err <= 1'b1;
      end
   end

   assert_bcd_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && word.sel == 2'(CHAN_SEL) && word.acc != ACC_LATCH && word.bcd) |=> cfg_err);
   assert_latch_keeps_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && word.sel == 2'(CHAN_SEL) && word.acc == ACC_LATCH) |=> $stable(cfg_err));
endmodule

// File: rtl/pit_byte_seq.sv
module pit_byte_seq #(
   parameter int BUS_W = 8,
   localparam int CNT_W = 2 * BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_wr,
   input  logic             data_rd,
   input  logic             latch_cmd,
   input  logic [CNT_W-1:0] live_cnt,
   output logic             wr_lo,
   output logic             wr_hi,
   output logic [BUS_W-1:0] rd_byte
);
   logic             rd_ptr, wr_ptr, latch_on;
   logic [CNT_W-1:0] latch_val, src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr    <= 1'b0;
         wr_ptr    <= 1'b0;
         latch_on  <= 1'b0;
         latch_val <= '0;
      end else begin
         if (latch_cmd && !latch_on) begin
            latch_on  <= 1'b1;
            latch_val <= live_cnt;
            rd_ptr    <= 1'b0;
         end else if (data_rd) begin
            rd_ptr <= ~rd_ptr;
            if (rd_ptr) latch_on <= 1'b0;
         end
         if (data_wr) wr_ptr <= ~wr_ptr;
      end
   end

   assign wr_lo   = data_wr && !wr_ptr;
   assign wr_hi   = data_wr && wr_ptr;
   assign src     = latch_on ? latch_val : live_cnt;
   assign rd_byte = rd_ptr ? src[CNT_W-1:BUS_W] : src[BUS_W-1:0];

   assert_latch_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_on && !(data_rd && rd_ptr)) |=> (latch_on && $stable(latch_val)));
   assert_latch_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_on && data_rd && rd_ptr && !latch_cmd) |=> !latch_on);
endmodule

// File: rtl/pit_downcounter.sv
module pit_downcounter #(
   parameter int BUS_W = 8,
   localparam int CNT_W = 2 * BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [BUS_W-1:0] wbyte,
   input  logic             tick_en,
   input  logic             periodic,
   output logic [CNT_W-1:0] cnt,
   output logic             out_q
);
   logic [CNT_W-1:0] period_q, loaded;
   logic             run;

   assign loaded = {wbyte, cnt[BUS_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         period_q <= '0;
         run      <= 1'b0;
         out_q    <= 1'b0;
      end else if (wr_lo) begin
         cnt[BUS_W-1:0] <= wbyte;
         run            <= 1'b0;
         out_q          <= 1'b0;
      end else if (wr_hi) begin
         cnt      <= loaded;
         period_q <= loaded;
         run      <= (loaded != '0);
      end else if (run && tick_en) begin
         if (cnt == CNT_W'(1)) begin
            if (periodic) begin
               cnt <= period_q;
            end else begin
               cnt   <= '0;
               run   <= 1'b0;
               out_q <= 1'b1;
            end
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assert_lo_write_drops_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (!out_q && !run));
   assert_out_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q && !wr_lo) |=> out_q);
   assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick_en && !wr_lo && !wr_hi && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_lo && !wr_hi) |=> $stable(cnt));
   assert_reload_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick_en && periodic && !wr_lo && !wr_hi && cnt == CNT_W'(1)) |=> (!out_q && cnt == period_q));
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
   parameter int BUS_W    = 8,
   parameter int CHAN_SEL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             ctrl_sel,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             out_q,
   output logic             cfg_err
);
   localparam int CNT_W = 2 * BUS_W;

   generate
      if (BUS_W < 8) begin : g_bad_bus
         $error("pit_channel: BUS_W must be at least 8");
      end
      if (CHAN_SEL < 0 || CHAN_SEL > 2) begin : g_bad_sel
         $error("pit_channel: CHAN_SEL must be 0, 1 or 2");
      end
   endgenerate

   logic             latch_cmd, periodic, wr_lo, wr_hi;
   logic [CNT_W-1:0] live_cnt;
   logic [BUS_W-1:0] rd_byte;

   pit_ctrl_decode #(.CHAN_SEL(CHAN_SEL)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (wr_en && ctrl_sel),
      .ctrl_byte (wdata[7:0]),
      .latch_cmd (latch_cmd),
      .periodic  (periodic),
      .cfg_err   (cfg_err)
   );

   pit_byte_seq #(.BUS_W(BUS_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_wr   (wr_en && !ctrl_sel),
      .data_rd   (rd_en && !ctrl_sel),
      .latch_cmd (latch_cmd),
      .live_cnt  (live_cnt),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .rd_byte   (rd_byte)
   );

   pit_downcounter #(.BUS_W(BUS_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wbyte    (wdata),
      .tick_en  (tick_en),
      .periodic (periodic),
      .cnt      (live_cnt),
      .out_q    (out_q)
   );

   assign rdata = ctrl_sel ? '0 : rd_byte;
endmodule

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ctrl_sel = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       out_q, cfg_err;
   int         n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   pit_channel u_pit_channel (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
      .ctrl_sel(ctrl_sel), .wdata(wdata), .rdata(rdata), .out_q(out_q), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic c, input logic [7:0] d);
      @(negedge clk); ctrl_sel = c; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; ctrl_sel = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk); ctrl_sel = 1'b0; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic rd_pair(input string req, input int lo, input int hi);
      logic [7:0] v;
      rd(v); chk(req, v, lo);
      rd(v); chk(req, v, hi);
   endtask

   task automatic tick(input int n);
      @(negedge clk); tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic load(input logic [7:0] lo, input logic [7:0] hi);
      wr(1'b0, lo); wr(1'b0, hi);
   endtask

   task automatic t_reset;
      chk("R1 out", out_q, 0); chk("R1 err", cfg_err, 0);
      rd_pair("R1 count", 8'h00, 8'h00);
   endtask

   task automatic t_load_and_count;
      wr(1'b1, 8'h30);
      chk("R10 valid clears", cfg_err, 0);
      load(8'h34, 8'h12);
      rd_pair("R6 loaded", 8'h34, 8'h12);
      tick(5);
      rd_pair("R7 five ticks", 8'h2F, 8'h12);
      repeat (3) @(negedge clk);
      rd_pair("R7 no tick hold", 8'h2F, 8'h12);
   endtask

   task automatic t_mode0;
      wr(1'b1, 8'h30);
      load(8'h03, 8'h00);
      tick(2); chk("R8 before expiry", out_q, 0);
      tick(1); chk("R8 expiry", out_q, 1);
      tick(4); chk("R8 sticky", out_q, 1);
      rd_pair("R8 holds zero", 8'h00, 8'h00);
      wr(1'b0, 8'h05); chk("R5 lo write drops out", out_q, 0);
      tick(3);
      wr(1'b0, 8'h00);
      rd_pair("R5 halted by lo write", 8'h05, 8'h00);
      load(8'h00, 8'h00); tick(3);
      chk("R6 zero never fires", out_q, 0);
      rd_pair("R6 zero stays", 8'h00, 8'h00);
   endtask

   task automatic t_latch;
      logic [7:0] v;
      wr(1'b1, 8'h30);
      load(8'h00, 8'h01);
      tick(2);
      wr(1'b1, 8'h00);
      tick(3);
      wr(1'b1, 8'h00);
      rd(v); chk("R3 latched lo, repeat ignored", v, 8'hFE);
      tick(2);
      rd(v); chk("R4 latched hi", v, 8'h00);
      rd_pair("R4 released live", 8'hF9, 8'h00);
      rd(v); chk("R4 live lo", v, 8'hF9);
      tick(1);
      wr(1'b1, 8'h00);
      rd_pair("R3 pointer reset to lo", 8'hF8, 8'h00);
   endtask

   task automatic t_periodic;
      wr(1'b1, 8'h34);
      chk("R10 mode2 ok", cfg_err, 0);
      load(8'h04, 8'h00);
      tick(3); rd_pair("R9 at one", 8'h01, 8'h00);
      tick(1); rd_pair("R9 reload", 8'h04, 8'h00);
      chk("R9 out low", out_q, 0);
      tick(4); rd_pair("R9 reload again", 8'h04, 8'h00);
      wr(1'b1, 8'h36);
      load(8'h02, 8'h00);
      tick(2); rd_pair("R9 mode3 reload", 8'h02, 8'h00);
      chk("R9 mode3 out low", out_q, 0);
   endtask

   task automatic t_errors;
      wr(1'b1, 8'h10); chk("R10 access 01", cfg_err, 1);
      wr(1'b1, 8'h30); chk("R10 cleared", cfg_err, 0);
      wr(1'b1, 8'h31); chk("R10 bcd", cfg_err, 1);
      wr(1'b1, 8'h30);
      wr(1'b1, 8'h32); chk("R10 mode1", cfg_err, 1);
      wr(1'b1, 8'h00); chk("R10 latch keeps err", cfg_err, 1);
      rd_pair("R4 drain latch", 8'h02, 8'h00);
      wr(1'b1, 8'h30); chk("R10 cleared again", cfg_err, 0);
      wr(1'b1, 8'hC0); chk("R10 readback", cfg_err, 1);
      wr(1'b1, 8'h30);
   endtask

   task automatic t_other_select;
      load(8'h50, 8'h00);
      wr(1'b1, 8'h40);
      tick(2);
      rd_pair("R2 other select no latch", 8'h4E, 8'h00);
      wr(1'b1, 8'h52); chk("R2 other select no err", cfg_err, 0);
      wr(1'b1, 8'h80); tick(1);
      rd_pair("R2 select 2 no latch", 8'h4D, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_and_count();
      t_mode0();
      t_latch();
      t_periodic();
      t_errors();
      t_other_select();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule